// File: doc/BRIEF.md
# TLP Header Format and Size Checker

This block inspects the header of an arriving transaction layer packet and decides whether its shape is legal. The inputs are the header size (three or four DW), a request class code, the address field, the Address Type field, the Length field, a payload-present flag, the digest (TD) bit and the total DW count seen by an upstream framer. The block runs three checks. The first compares the observed size with the size the header implies. The second enforces the rules on 32-bit and 64-bit address format for I/O and memory requests. The third rejects a non-zero Address Type on any request class where that field is reserved.

A one-cycle start pulse tells the block that its inputs are valid. On that clock edge the block registers a result word. The word holds one flag for each error, a combined malformed flag, a digest-present flag and a flag telling the ECRC logic downstream whether to check the final DW. It also holds an advisory flag for a 64-bit memory request whose upper address half is zero, because the handling of that case is left unspecified. The result stays unchanged until the next start pulse.

Top module: `tlp_fmt_checker`

## Requirements
- R1: While reset is asserted and after it is released, and before the first start, resValid and all result flags are 0.
- R2: On a clock edge where start is 1, the result is computed from the inputs present at that edge and appears right after that edge, and resValid becomes 1. With start at 0, the result and resValid do not change, whatever the other inputs do.
- R3: The payload size in DW is the Length field when hasPayload is 1, where a Length value of 0 means 1024 DW. It is 0 when hasPayload is 0, and the Length field is then ignored.
- R4: sizeErr is 1 exactly when obsLenDw differs from the header size plus the payload size plus one DW when tdBit is 1. The header size is 4 DW when hdr4Dw is 1 and 3 DW when hdr4Dw is 0.
- R5: digestPresent equals the captured tdBit.
- R6: checkEcrc is 1 only when tdBit is 1, ecrcEn is 1 and sizeErr is 0. With ecrcEn at 0, checkEcrc stays 0 even when TD is set.
- R7: The class codes are 0 memory read, 1 memory write, 2 AtomicOp, 3 I/O read and 4 I/O write. Codes 5 to 7 are other requests. fmtErr is 1 for class 3 or 4 when hdr4Dw is 1.
- R8: upperZeroAdv is 1 for class 0, 1 or 2 when hdr4Dw is 1 and addr[63:32] is zero. This advisory does not set malformed.
- R9: atErr is 1 when the class is 3 to 7 and atField is not zero. The Address Type value is ignored for classes 0 to 2.
- R10: malformed is the OR of sizeErr, fmtErr and atErr.
- R11: With a three-DW header, addr[63:32] is ignored and upperZeroAdv stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture pulse; inputs valid this cycle |
| hdr4Dw | input | 1 | 1 = four-DW header, 0 = three-DW header |
| reqClass | input | 3 | Request class code (see R7) |
| addr | input | 64 | Address field as received |
| atField | input | 2 | Address Type field |
| lenField | input | 10 | Length field in DW, 0 = 1024 |
| hasPayload | input | 1 | Packet carries a data payload |
| tdBit | input | 1 | Digest-present bit from the header |
| obsLenDw | input | 11 | Total packet size in DW counted by the framer |
| ecrcEn | input | 1 | Receiver supports ECRC checking |
| resValid | output | 1 | At least one result has been captured |
| malformed | output | 1 | Any size, format or Address Type error |
| sizeErr | output | 1 | Observed size differs from implied size |
| fmtErr | output | 1 | I/O request in four-DW format |
| atErr | output | 1 | Non-zero reserved Address Type |
| upperZeroAdv | output | 1 | 64-bit memory request addressing below 4 GB |
| digestPresent | output | 1 | Last DW is a digest |
| checkEcrc | output | 1 | Last DW is ECRC to be checked |

## Verification
The result register is the only internal state. If a capture is missed, or the register is loaded on a cycle without start, the output flags disagree with the reference model in the first cycle after the start, or in the hold cycle that follows, where the inputs are scrambled on purpose. An error in the implied-size sum shows up as a wrong sizeErr, and also as a wrong checkEcrc whenever TD is set. The bench therefore aims at the 1024-DW Length encoding, digests with and without ECRC support, and observed sizes that miss the implied size by one DW. Class and header mix-ups show up on fmtErr, atErr or upperZeroAdv in the same cycle as the capture.

// File: rtl/tlp_fmt_pkg.sv
package tlp_fmt_pkg;
  localparam logic [2:0] CLS_MRD    = 3'd0;
  localparam logic [2:0] CLS_MWR    = 3'd1;
  localparam logic [2:0] CLS_ATOMIC = 3'd2;
  localparam logic [2:0] CLS_IORD   = 3'd3;
  localparam logic [2:0] CLS_IOWR   = 3'd4;

  typedef struct packed {
    logic capture;
    logic markValid;
  } ctrlStrobeT;

  typedef struct packed {
    logic malformed;
    logic sizeErr;
    logic fmtErr;
    logic atErr;
    logic upperZeroAdv;
    logic digestPresent;
    logic checkEcrc;
  } resultT;
endpackage

// File: rtl/tlp_fmt_ctrl.sv
module tlp_fmt_ctrl
  import tlp_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output ctrlStrobeT strobes,
  output logic       resValid
);
  always_comb begin
    strobes.capture   = start;
    strobes.markValid = start & ~resValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else if (strobes.markValid) resValid <= 1'b1;
  end

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resValid);
  // R2
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> resValid);
endmodule

// File: rtl/tlp_fmt_datapath.sv
module tlp_fmt_datapath
  import tlp_fmt_pkg::*;
#(
  parameter int LEN_W    = 10,
  parameter int OBS_W    = 11,
  parameter int ADDR_W   = 64,
  parameter int AT_W     = 2,
  parameter bit CHECK_AT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic              hdr4Dw,
  input  logic [2:0]        reqClass,
  input  logic [ADDR_W-1:0] addr,
  input  logic [AT_W-1:0]   atField,
  input  logic [LEN_W-1:0]  lenField,
  input  logic              hasPayload,
  input  logic              tdBit,
  input  logic [OBS_W-1:0]  obsLenDw,
  input  logic              ecrcEn,
  output resultT            res
);
  localparam int PAY_W   = LEN_W + 1;
  localparam int SUM_W   = OBS_W + 1;
  localparam int MAX_PAY = 1 << LEN_W;
  localparam int HI_W    = ADDR_W - 32;

  logic [PAY_W-1:0] payDw;
  logic [SUM_W-1:0] impliedDw;
  logic             isMem, isIo, sizeBad, atBad;
  resultT           nextRes;

  always_comb begin
    if (!hasPayload)          payDw = '0;
    else if (lenField == '0)  payDw = PAY_W'(MAX_PAY);
    else                      payDw = {1'b0, lenField};
    impliedDw = (hdr4Dw ? SUM_W'(4) : SUM_W'(3)) + SUM_W'(payDw) + SUM_W'(tdBit);
    sizeBad   = impliedDw != {1'b0, obsLenDw};
    isMem     = (reqClass == CLS_MRD) || (reqClass == CLS_MWR) || (reqClass == CLS_ATOMIC);
    isIo      = (reqClass == CLS_IORD) || (reqClass == CLS_IOWR);
  end

  generate
    if (CHECK_AT) begin : g_atCheck
      assign atBad = !isMem && (atField != '0);
    end else begin : g_atSkip
      assign atBad = 1'b0;
    end
  endgenerate

  always_comb begin
    nextRes.sizeErr       = sizeBad;
    nextRes.fmtErr        = isIo && hdr4Dw;
    nextRes.atErr         = atBad;
    nextRes.upperZeroAdv  = isMem && hdr4Dw && (addr[ADDR_W-1 -: HI_W] == '0);
    nextRes.digestPresent = tdBit;
    nextRes.checkEcrc     = tdBit && ecrcEn && !sizeBad;
    nextRes.malformed     = sizeBad || nextRes.fmtErr || atBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) res <= '0;
    else if (strobes.capture) res <= nextRes;
  end

  // R2
  hold_between_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(res));
  // R5
  digest_follows_td_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> res.digestPresent == $past(tdBit));
  // R6
  no_ecrc_when_unsupported_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !ecrcEn) |=> !res.checkEcrc);
  // R8
  advisory_mem_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    res.upperZeroAdv |-> (!res.fmtErr && !res.atErr));
endmodule

// File: rtl/tlp_fmt_checker.sv
module tlp_fmt_checker
  import tlp_fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        hdr4Dw,
  input  logic [2:0]  reqClass,
  input  logic [63:0] addr,
  input  logic [1:0]  atField,
  input  logic [9:0]  lenField,
  input  logic        hasPayload,
  input  logic        tdBit,
  input  logic [10:0] obsLenDw,
  input  logic        ecrcEn,
  output logic        resValid,
  output logic        malformed,
  output logic        sizeErr,
  output logic        fmtErr,
  output logic        atErr,
  output logic        upperZeroAdv,
  output logic        digestPresent,
  output logic        checkEcrc
);
  ctrlStrobeT strobes;
  resultT     res;

  tlp_fmt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .resValid(resValid)
  );

  tlp_fmt_datapath #(.LEN_W(10), .OBS_W(11), .ADDR_W(64), .AT_W(2), .CHECK_AT(1'b1)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hdr4Dw(hdr4Dw), .reqClass(reqClass),
    .addr(addr), .atField(atField), .lenField(lenField), .hasPayload(hasPayload),
    .tdBit(tdBit), .obsLenDw(obsLenDw), .ecrcEn(ecrcEn), .res(res)
  );

  assign malformed     = res.malformed;
  assign sizeErr       = res.sizeErr;
  assign fmtErr        = res.fmtErr;
  assign atErr         = res.atErr;
  assign upperZeroAdv  = res.upperZeroAdv;
  assign digestPresent = res.digestPresent;
  assign checkEcrc     = res.checkEcrc;

  // R6
  ecrc_needs_digest_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkEcrc |-> digestPresent);
  // R1
  idle_until_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !(malformed || digestPresent || upperZeroAdv));
endmodule

// File: tb/test_tlp_fmt_checker.sv
`timescale 1ns/1ps
module test_tlp_fmt_checker;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic hdr4Dw = 0, hasPayload = 0, tdBit = 0, ecrcEn = 0;
  logic [2:0] reqClass = 0;
  logic [63:0] addr = 0;
  logic [1:0] atField = 0;
  logic [9:0] lenField = 0;
  logic [10:0] obsLenDw = 0;
  logic resValid, malformed, sizeErr, fmtErr, atErr, upperZeroAdv, digestPresent, checkEcrc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlp_fmt_checker i_tlp_fmt_checker (.*);

  typedef struct { bit mal, sz, fm, at, adv, dg, ce; } expT;

  function automatic int totalDw(bit h4, bit pay, logic [9:0] len, bit td);
    int p = pay ? ((len == 0) ? 1024 : int'(len)) : 0;
    return (h4 ? 4 : 3) + p + (td ? 1 : 0);
  endfunction

  function automatic expT refModel(bit h4, logic [2:0] c, logic [63:0] a, logic [1:0] at,
                                    logic [9:0] len, bit pay, bit td, logic [10:0] obs, bit ee);
    expT r;
    bit mem = (c <= 3'd2);
    bit io  = (c == 3'd3) || (c == 3'd4);
    r.sz  = int'(obs) != totalDw(h4, pay, len, td);
    r.fm  = io && h4;
    r.at  = !mem && (at != 0);
    r.adv = mem && h4 && (a[63:32] == 0);
    r.dg  = td;
    r.ce  = td && ee && !r.sz;
    r.mal = r.sz || r.fm || r.at;
    return r;
  endfunction

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, nm, act, exp);
    end
  endtask

  task automatic cmpAll(expT e, string tag);
    chk("R2", {tag, " resValid"}, resValid, 1'b1);
    chk("R10", {tag, " malformed"}, malformed, e.mal);
    chk("R4", {tag, " sizeErr"}, sizeErr, e.sz);
    chk("R7", {tag, " fmtErr"}, fmtErr, e.fm);
    chk("R9", {tag, " atErr"}, atErr, e.at);
    chk("R8", {tag, " upperZeroAdv"}, upperZeroAdv, e.adv);
    chk("R5", {tag, " digestPresent"}, digestPresent, e.dg);
    chk("R6", {tag, " checkEcrc"}, checkEcrc, e.ce);
  endtask

  task automatic doTxn(bit h4, logic [2:0] c, logic [63:0] a, logic [1:0] at, logic [9:0] len,
                       bit pay, bit td, logic [10:0] obs, bit ee, string tag);
    expT e = refModel(h4, c, a, at, len, pay, td, obs, ee);
    @(negedge clk);
    hdr4Dw = h4; reqClass = c; addr = a; atField = at; lenField = len;
    hasPayload = pay; tdBit = td; obsLenDw = obs; ecrcEn = ee; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmpAll(e, tag);
    // R2: scramble inputs without start, result must hold
    hdr4Dw = ~h4; reqClass = c ^ 3'd4; addr = ~a; atField = ~at; lenField = ~len;
    hasPayload = ~pay; tdBit = ~td; obsLenDw = ~obs; ecrcEn = ~ee;
    @(negedge clk);
    cmpAll(e, {tag, " hold R2"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "resValid in reset", resValid, 1'b0);
    chk("R1", "malformed in reset", malformed, 1'b0);
    chk("R1", "checkEcrc in reset", checkEcrc, 1'b0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "resValid after reset", resValid, 1'b0);
    chk("R1", "digestPresent after reset", digestPresent, 1'b0);

    // R3: Length 0 means 1024 DW
    doTxn(0, 3'd1, 64'h10, 0, 10'd0, 1, 0, 11'd1027, 1, "R3 len0 ok");
    doTxn(0, 3'd1, 64'h10, 0, 10'd0, 1, 0, 11'd3, 1, "R3 len0 short");
    // R3/R6: no payload ignores Length, digest checked
    doTxn(0, 3'd0, 64'h20, 0, 10'd55, 0, 1, 11'd4, 1, "R3 nopay R6 ecrc");
    doTxn(0, 3'd0, 64'h20, 0, 10'd55, 0, 1, 11'd4, 0, "R6 ecrc unsupported");
    doTxn(1, 3'd1, 64'h1_0000_0000, 0, 10'd8, 1, 1, 11'd12, 1, "R6 td size mismatch");
    // R4: off by one in each direction
    doTxn(1, 3'd1, 64'h2_0000_0000, 0, 10'd8, 1, 1, 11'd13, 1, "R4 exact");
    doTxn(1, 3'd1, 64'h2_0000_0000, 0, 10'd8, 1, 1, 11'd14, 1, "R4 long");
    // R7: I/O format
    doTxn(1, 3'd3, 64'h3_0000_0100, 0, 10'd1, 0, 0, 11'd4, 0, "R7 io 4dw");
    doTxn(0, 3'd4, 64'h100, 0, 10'd1, 1, 0, 11'd4, 0, "R7 io 3dw ok");
    // R8 / R11: upper address half zero
    doTxn(1, 3'd0, 64'h0000_0000_8000_0000, 0, 10'd4, 0, 0, 11'd4, 0, "R8 adv");
    doTxn(0, 3'd0, 64'h0000_0000_8000_0000, 0, 10'd4, 0, 0, 11'd3, 0, "R11 3dw");
    doTxn(0, 3'd2, 64'hdead_beef_0000_0040, 0, 10'd2, 1, 0, 11'd5, 0, "R11 3dw upper junk");
    // R9: reserved Address Type
    doTxn(0, 3'd5, 64'h0, 2'd2, 10'd1, 0, 0, 11'd3, 0, "R9 other at");
    doTxn(0, 3'd1, 64'h0, 2'd2, 10'd1, 1, 0, 11'd4, 0, "R9 mem at ok");
    doTxn(0, 3'd4, 64'h0, 2'd1, 10'd1, 1, 0, 11'd4, 0, "R9 io at");

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit h4 = 1'($urandom);
      logic [2:0] c = 3'($urandom);
      logic [63:0] a = {32'($urandom), 32'($urandom)};
      logic [1:0] at = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      logic [9:0] len = ($urandom % 8 == 0) ? 10'd0 : 10'($urandom);
      bit pay = 1'($urandom);
      bit td = 1'($urandom);
      bit ee = 1'($urandom);
      logic [10:0] obs;
      if ($urandom % 4 == 0) a[63:32] = 32'd0;
      case ($urandom % 4)
        0: obs = 11'($urandom);
        1: obs = 11'(totalDw(h4, pay, len, td) + 1);
        default: obs = 11'(totalDw(h4, pay, len, td));
      endcase
      doTxn(h4, c, a, at, len, pay, td, obs, ee, "rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule